// File: doc/BRIEF.md
# Comma-Free Sync Word Generator

The block produces the serial synchronization line that travels beside a bank of time-multiplexed channels. Once per slot a transfer strobe loads one 20-bit code word into a shift register. The word is picked from the commutation mode of the channel that owns the next slot. That channel is found by taking the currently active slot line and stepping one position further around the ring. The word then leaves most significant bit first, one bit per bit strobe. The word for the first channel of each long cycle is sent complemented so that a receiver can find the cycle start.

Each data bit is biphase coded against the bit clock: the first half-bit carries the complement of the data bit and the second half-bit carries the bit itself. The coded line is then re-registered on every half-bit strobe, which delays it by half a bit and removes any glitch from the coding XOR. All timing comes from single-cycle strobes in one system clock domain: a bit strobe, a mid-bit strobe and the slot transfer strobe. The three code words are parameters. Elaboration rejects a set that is not comma-free together with its complements.

Top module: `sync_word_gen`

## Requirements
- R1: After reset `sync_out` is 0, and it stays 0 until the first bit of the first loaded word reaches the coder.
- R2: On a transfer, the channel mode strap selects the word: 2'b00 gives the one-subchannel word (default 20'hFF596), 2'b01 the two-subchannel word (20'hFF34D), 2'b10 the four-subchannel word (20'hFF669), and 2'b11 falls back to the one-subchannel word. A transfer with no slot line active also sends the one-subchannel word.
- R3: When slot line k is active at a transfer, the strap of channel (k+1) mod NCH is used. The strap for channel c sits at `mode_straps[2c+1:2c]`, so slot line NCH-1 selects the strap of channel 0.
- R4: Bits leave MSB first, one per bit strobe. After the 20 bits of a word the register supplies 0 bits until the next transfer.
- R5: When `inv_cmd` is high in the transfer cycle, every bit of the selected word is complemented.
- R6: The bit that enters at bit strobe k is output, delayed by half a bit, as its complement from mid strobe k up to bit strobe k+1. The bit itself is output from bit strobe k+1 up to the next mid strobe.
- R7: `sync_out` changes only in the cycle after a bit strobe or a mid strobe.
- R8: When a transfer and a bit strobe occur in the same cycle, the new word's MSB is the bit that enters at that strobe. Any unsent bits of the previous word are discarded.
- R9: A transfer between bit strobes replaces the unsent bits. The bit already in the coder completes, and the new MSB enters at the next bit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe at the start of each bit period |
| mid_stb | input | 1 | One-cycle strobe at the middle of each bit period |
| xfer_stb | input | 1 | One-cycle slot transfer strobe that loads the next word |
| slot_ring | input | NCH | One-hot slot lines from the ring counter |
| mode_straps | input | 2*NCH | Per-channel commutation mode straps, 2 bits per channel |
| inv_cmd | input | 1 | Complement the word loaded by this transfer |
| sync_out | output | 1 | Biphase-coded, half-bit retimed sync line |

## Verification
The transfer strobe and the bit strobe can land in the same cycle. The load then has to win over the shift, and the incoming MSB has to enter the coder at once. The bench provokes this by raising the transfer in the same cycle as a bit strobe, both at the start of a word and partway through an earlier word. It then expects the new word's bits from that very bit period on. It also judges the opposite case: a transfer placed between strobes must leave the bit already in flight alone and start the new word one period later.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

   typedef enum logic [1:0] {
      STRAP_ONE   = 2'b00,
      STRAP_TWO   = 2'b01,
      STRAP_FOUR  = 2'b10,
      STRAP_SPARE = 2'b11
   } strap_e;

   localparam int STRAP_W = 2;

endpackage

// File: rtl/sync_word_pick.sv
module sync_word_pick
   import sync_gen_pkg::*;
#(
   parameter int NCH = 20,
   parameter int WORD_W = 20,
   parameter logic [WORD_W-1:0] W_ONE = 20'hFF596,
   parameter logic [WORD_W-1:0] W_TWO = 20'hFF34D,
   parameter logic [WORD_W-1:0] W_FOUR = 20'hFF669
) (
   input  logic [NCH-1:0]         slot_ring,
   input  logic [STRAP_W*NCH-1:0] mode_straps,
   input  logic                   inv_cmd,
   output logic [WORD_W-1:0]      word
);

   logic [NCH-1:0] hit_two;
   logic [NCH-1:0] hit_four;
   logic [WORD_W-1:0] base;

   for (genvar k = 0; k < NCH; k++) begin : g_slot
      localparam int NXT = (k + 1) % NCH;
      strap_e nxt_mode;
      assign nxt_mode   = strap_e'(mode_straps[STRAP_W*NXT +: STRAP_W]);
      assign hit_two[k]  = slot_ring[k] & (nxt_mode == STRAP_TWO);
      assign hit_four[k] = slot_ring[k] & (nxt_mode == STRAP_FOUR);
   end

   always_comb begin
      if (|hit_four)      base = W_FOUR;
      else if (|hit_two)  base = W_TWO;
      else                base = W_ONE;
      word = base ^ {WORD_W{inv_cmd}};
   end

endmodule

// File: rtl/sync_word_shifter.sv
module sync_word_shifter #(
   parameter int WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              xfer_stb,
   input  logic [WORD_W-1:0] word,
   output logic              cur_bit,
   output logic              primed
);

   logic [WORD_W-1:0] sreg;
   logic              armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg    <= '0;
         cur_bit <= 1'b0;
         armed   <= 1'b0;
         primed  <= 1'b0;
      end else begin
         if (bit_stb) begin
            if (xfer_stb) begin
               cur_bit <= word[WORD_W-1];
               sreg    <= {word[WORD_W-2:0], 1'b0};
            end else begin
               cur_bit <= sreg[WORD_W-1];
               sreg    <= {sreg[WORD_W-2:0], 1'b0};
            end
            if (xfer_stb || armed) primed <= 1'b1;
         end else if (xfer_stb) begin
            sreg <= word;
         end
         if (xfer_stb) armed <= 1'b1;
      end
   end

endmodule

// File: rtl/sync_biphase_retime.sv
module sync_biphase_retime (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic mid_stb,
   input  logic cur_bit,
   input  logic primed,
   output logic sync_out
);

   logic phase_hi;
   logic coded;

   assign coded = primed & (cur_bit ^ phase_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_hi <= 1'b0;
         sync_out <= 1'b0;
      end else begin
         if (bit_stb)      phase_hi <= 1'b1;
         else if (mid_stb) phase_hi <= 1'b0;
         if (bit_stb || mid_stb) sync_out <= coded;
      end
   end

endmodule

// File: rtl/sync_word_gen.sv
module sync_word_gen
   import sync_gen_pkg::*;
#(
   parameter int NCH = 20,
   parameter int WORD_W = 20,
   parameter logic [WORD_W-1:0] W_ONE = 20'hFF596,
   parameter logic [WORD_W-1:0] W_TWO = 20'hFF34D,
   parameter logic [WORD_W-1:0] W_FOUR = 20'hFF669
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bit_stb,
   input  logic                   mid_stb,
   input  logic                   xfer_stb,
   input  logic [NCH-1:0]         slot_ring,
   input  logic [STRAP_W*NCH-1:0] mode_straps,
   input  logic                   inv_cmd,
   output logic                   sync_out
);

   function automatic bit comma_free_set(logic [WORD_W-1:0] a1,
                                         logic [WORD_W-1:0] a2,
                                         logic [WORD_W-1:0] a4);
      logic [WORD_W-1:0]   set [6];
      logic [2*WORD_W-1:0] cat;
      logic [WORD_W-1:0]   win;
      bit ok;
      ok = 1'b1;
      set[0] = a1;  set[1] = a2;  set[2] = a4;
      set[3] = ~a1; set[4] = ~a2; set[5] = ~a4;
      for (int a = 0; a < 6; a++) begin
         for (int b = 0; b < 6; b++) begin
            if (a != b && set[a] == set[b]) ok = 1'b0;
            cat = {set[a], set[b]};
            for (int s = 1; s < WORD_W; s++) begin
               win = cat[2*WORD_W-1-s -: WORD_W];
               for (int c = 0; c < 6; c++)
                  if (win == set[c]) ok = 1'b0;
            end
         end
      end
      return ok;
   endfunction

   localparam bit COMMA_OK = comma_free_set(W_ONE, W_TWO, W_FOUR);

   if (NCH < 2) begin : g_bad_nch
      $error("sync_word_gen: NCH must be at least 2");
   end
   if (WORD_W < 2) begin : g_bad_width
      $error("sync_word_gen: WORD_W must be at least 2");
   end
   if (!COMMA_OK) begin : g_bad_code
      $error("sync_word_gen: code words and complements are not comma-free");
   end

   logic [WORD_W-1:0] word;
   logic              cur_bit;
   logic              primed;

   sync_word_pick #(
      .NCH(NCH), .WORD_W(WORD_W),
      .W_ONE(W_ONE), .W_TWO(W_TWO), .W_FOUR(W_FOUR)
   ) u_pick (
      .slot_ring  (slot_ring),
      .mode_straps(mode_straps),
      .inv_cmd    (inv_cmd),
      .word       (word)
   );

   sync_word_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_stb (bit_stb),
      .xfer_stb(xfer_stb),
      .word    (word),
      .cur_bit (cur_bit),
      .primed  (primed)
   );

   sync_biphase_retime u_code (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_stb (bit_stb),
      .mid_stb (mid_stb),
      .cur_bit (cur_bit),
      .primed  (primed),
      .sync_out(sync_out)
   );

endmodule

// File: rtl/sync_word_gen_chk.sv
module sync_word_gen_chk #(
   parameter int WORD_W = 20
) (
   input logic clk,
   input logic rst_n,
   input logic bit_stb,
   input logic mid_stb,
   input logic xfer_stb,
   input logic sync_out
);

   localparam int CNT_MAX = WORD_W + 2;
   localparam int CNT_W = $clog2(CNT_MAX + 1) + 1;

   logic             seen;
   logic [CNT_W-1:0] bits_since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen       <= 1'b0;
         bits_since <= '0;
      end else begin
         if (xfer_stb) seen <= 1'b1;
         if (xfer_stb)
            bits_since <= bit_stb ? CNT_W'(1) : '0;
         else if (bit_stb && bits_since != CNT_W'(CNT_MAX))
            bits_since <= bits_since + 1'b1;
      end
   end

   a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> !sync_out);

   a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_stb || mid_stb) |=> $stable(sync_out));

   a_r6_bit_edge_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !xfer_stb && seen && bits_since >= CNT_W'(1))
      |=> (sync_out != $past(sync_out)));

   a_r4_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !xfer_stb && seen && bits_since >= CNT_W'(WORD_W + 1))
      |=> !sync_out);

endmodule

bind sync_word_gen sync_word_gen_chk #(.WORD_W(WORD_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bit_stb (bit_stb),
   .mid_stb (mid_stb),
   .xfer_stb(xfer_stb),
   .sync_out(sync_out)
);

// File: tb/sim_sync_word_gen.sv
`timescale 1ns/1ps
module sim_sync_word_gen;

   localparam int NCH = 20;
   localparam int WW = 20;
   localparam logic [WW-1:0] EW1 = 20'hFF596;
   localparam logic [WW-1:0] EW2 = 20'hFF34D;
   localparam logic [WW-1:0] EW4 = 20'hFF669;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bit_stb = 1'b0;
   logic            mid_stb = 1'b0;
   logic            xfer_stb = 1'b0;
   logic [NCH-1:0]  slot_ring = '0;
   logic [2*NCH-1:0] mode_straps = '0;
   logic            inv_cmd = 1'b0;
   logic            sync_out;
   int              ph = 0;
   int              n_chk = 0;
   int              n_fail = 0;
   bit              done = 1'b0;

   always #2.5 clk = ~clk;

   sync_word_gen u0 (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .mid_stb(mid_stb),
      .xfer_stb(xfer_stb), .slot_ring(slot_ring), .mode_straps(mode_straps),
      .inv_cmd(inv_cmd), .sync_out(sync_out)
   );

   initial begin
      forever begin
         @(negedge clk);
         ph = (ph + 1) % 16;
         bit_stb = (ph == 0);
         mid_stb = (ph == 8);
      end
   end

   task automatic check(input logic got, input logic exp, input string req, input string what);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic at_ph(input int p);
      do @(posedge clk); while (ph != p);
      @(negedge clk);
   endtask

   task automatic set_strap(input int ch, input logic [1:0] code);
      mode_straps[2*ch +: 2] = code;
   endtask

   task automatic load(input int slot_idx, input logic inv, input bit coinc);
      do @(posedge clk); while (ph != (coinc ? 15 : 3));
      @(negedge clk);
      xfer_stb  = 1'b1;
      slot_ring = (slot_idx < 0) ? '0 : (NCH'(1) << slot_idx);
      inv_cmd   = inv;
      @(negedge clk);
      xfer_stb  = 1'b0;
      slot_ring = '0;
      inv_cmd   = 1'b0;
      if (!coinc) at_ph(0);
   endtask

   task automatic check_word(input logic [WW-1:0] w, input int nbits, input string req);
      for (int i = 0; i < nbits; i++) begin
         at_ph(12);
         check(sync_out, ~w[WW-1-i], req, $sformatf("first half of bit %0d", i));
         at_ph(4);
         check(sync_out, w[WW-1-i], req, $sformatf("second half of bit %0d", i));
      end
   endtask

   task automatic t_reset;
      check(sync_out, 1'b0, "R1", "right after reset");
      for (int i = 0; i < 3; i++) begin
         at_ph(4);  check(sync_out, 1'b0, "R1", "idle before load, half A");
         at_ph(12); check(sync_out, 1'b0, "R1", "idle before load, half B");
      end
   endtask

   task automatic t_mode_one;
      set_strap(5, 2'b00); set_strap(4, 2'b10);
      load(4, 1'b0, 1'b0);
      check_word(EW1, WW, "R3");
   endtask

   task automatic t_mode_two_coinc;
      set_strap(8, 2'b01); set_strap(7, 2'b00);
      load(7, 1'b0, 1'b1);
      check_word(EW2, WW, "R8");
   endtask

   task automatic t_mode_four_hold;
      logic v0;
      set_strap(10, 2'b10);
      load(9, 1'b0, 1'b1);
      check_word(EW4, 2, "R2");
      at_ph(0);
      v0 = sync_out;
      for (int c = 1; c < 8; c++) begin
         @(negedge clk);
         check(sync_out, v0, "R7", $sformatf("hold in cycle %0d after bit strobe", c));
      end
      check_word(EW4 << 3, WW - 3, "R2");
   endtask

   task automatic t_spare_strap;
      set_strap(3, 2'b11);
      load(2, 1'b0, 1'b0);
      check_word(EW1, WW, "R2");
   endtask

   task automatic t_wrap;
      set_strap(0, 2'b10); set_strap(19, 2'b01);
      load(19, 1'b0, 1'b1);
      check_word(EW4, WW, "R3");
   endtask

   task automatic t_invert;
      load(19, 1'b1, 1'b0);
      check_word(~EW4, WW, "R5");
   endtask

   task automatic t_no_slot_tail;
      load(-1, 1'b0, 1'b1);
      check_word(EW1, WW, "R2");
      for (int j = 0; j < 3; j++) begin
         at_ph(12); check(sync_out, 1'b1, "R4", "zero fill, first half");
         at_ph(4);  check(sync_out, 1'b0, "R4", "zero fill, second half");
      end
   endtask

   task automatic t_reload_between;
      load(7, 1'b0, 1'b1);
      check_word(EW2, 5, "R9");
      load(9, 1'b0, 1'b0);
      check_word(EW4, WW, "R9");
   endtask

   task automatic t_reload_coinc;
      load(4, 1'b0, 1'b1);
      check_word(EW1, 3, "R8");
      load(7, 1'b0, 1'b1);
      check_word(EW2, WW, "R8");
   endtask

   task automatic t_biphase;
      logic [WW-1:0] w;
      w = EW2;
      load(7, 1'b0, 1'b0);
      at_ph(12); check(sync_out, ~w[WW-1], "R6", "complement after mid strobe");
      at_ph(4);  check(sync_out, w[WW-1], "R6", "true bit after next bit strobe");
      check_word(w << 1, WW - 1, "R4");
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_mode_one;
      t_mode_two_coinc;
      t_mode_four_hold;
      t_spare_strap;
      t_wrap;
      t_invert;
      t_no_slot_tail;
      t_reload_between;
      t_reload_coinc;
      t_biphase;
      done = 1'b1;
      finish_run;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run;
      end
   end

endmodule